// File: doc/BRIEF.md
# Paired-Channel PWM Generator with Dead-Time Insertion

This block produces four pulse-width modulated outputs. The channels are organised as two pairs. Each pair owns one tick generator, made of an 8-bit prescaler followed by a power-of-two divider, and one dead-time stage. Every channel has its own 16-bit down-counter, a period (reload) value, a compare value and a mode bit. The mode bit selects free-running auto-reload operation or a single pulse that stops by itself. A channel asserts a sticky per-channel flag each time its counter expires.

Software programs the block through a single-cycle write port. When dead time is enabled on a pair, the pair's second output is no longer driven by its own channel. It carries the complement of the first channel's waveform. Both rising edges are then held back by a programmable number of clock cycles, so the two outputs are never high together. This is the usual arrangement for driving the high and low switches of a half bridge.

Register map (write address, decimal):
- Pair p prescaler: 3p.
- Pair p divider select: 3p+1.
- Pair p dead-time register: 3p+2.
- Channel c period: 6+2c.
- Channel c compare: 7+2c.
- Control: 14.
- Flag clear: 15.

Top module: `pwm_quad`

## Requirements
- R1: After synchronous reset all outputs, all channel-active bits and all interrupt flags are 0.
- R2: A pair's counters advance once every (P+1)·D clock cycles. P is the 8-bit prescaler value. D is 1, 2, 4, 8 or 16 for divider codes 0 to 4 (bits [2:0] of the divider register), and any code above 4 also gives D = 16.
- R3: In auto-reload mode a channel counts period, period-1, …, 0 and then reloads, one step per tick. Its output is high for the ticks where the count is strictly greater than the compare value, so it is high for period-compare of every period+1 ticks.
- R4: When the compare value is greater than or equal to the period, the output stays low.
- R5: In one-shot mode (control bit 4+c set) the channel runs once from the period down to 0. On the tick at zero it stops: its active bit clears, its output stays low and its flag is set.
- R6: A channel's flag (irq_flag[c]) is set on each tick where its counter is at zero. Writing a 1 to bit c of the flag-clear register clears it, and a 0 bit leaves it unchanged.
- R7: With dead time enabled (bit 8 of the pair's dead-time register, count in bits [7:0]), the second output of the pair follows the inverse of the first channel's waveform while that channel is active. Each output's rise is delayed by the dead-time count in clock cycles, and each fall is not delayed.
- R8: With dead time enabled, the two outputs of a pair are never high in the same cycle.
- R9: With dead time disabled, each output follows its own channel one clock later, and the channels of a pair run independently.
- R10: Writing the control register (bit c = enable of channel c) starts an idle channel from its period value when the bit is 1, and stops the channel with a low output when the bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| pwm_out | output | 4 | PWM outputs, one per channel |
| ch_active | output | 4 | Channel running indication |
| irq_flag | output | 4 | Sticky counter-expiry flags |

## Verification
The bench uses the default build: two pairs, 16-bit counters and a 4-bit address. With a prescaler of 0 and a divider code of 0, the counters step every clock. Short periods then cover the duty, compare-limit, one-shot and dead-time cases within a few dozen cycles, and high-time counts over whole periods give exact expectations regardless of phase. The second pair is run with prescaler 1 and divider codes 1 and 7, which checks the clamped divider code against the slow-tick arithmetic.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PRE_W = 8;
    localparam int DT_W  = 8;
    localparam int DIV_W = 4;

    typedef enum logic [2:0] {
        DIV_1  = 3'd0,
        DIV_2  = 3'd1,
        DIV_4  = 3'd2,
        DIV_8  = 3'd3,
        DIV_16 = 3'd4
    } div_sel_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        div_sel_e         div;
        logic             dz_en;
        logic [DT_W-1:0]  dt;
    } pair_cfg_t;

    // Mask over the divider counter: a tick fires when all masked bits are one.
    function automatic logic [DIV_W-1:0] div_mask(div_sel_e s);
        case (s)
            DIV_1:   return 4'b0000;
            DIV_2:   return 4'b0001;
            DIV_4:   return 4'b0011;
            DIV_8:   return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] pre,
    input  div_sel_e         div,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_tick;
    logic [DIV_W-1:0] mask;

    assign pre_tick = (pre_cnt >= pre);
    assign mask     = div_mask(div);
    assign tick     = pre_tick && ((div_cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
            div_cnt <= div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R2: with a nonzero prescaler two ticks can never be adjacent
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && pre != '0) |=> (!tick || !$stable(pre)));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             period_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ctrl_wr,
    input  logic             en_in,
    input  logic             os_in,
    input  logic             clr_wr,
    output logic             raw,
    output logic             active,
    output logic             flag
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt;
    logic             en;
    logic             os;
    logic             start;
    logic             stop;
    logic             expire;

    assign start  = ctrl_wr && en_in && !en;
    assign stop   = ctrl_wr && !en_in;
    assign expire = en && tick && (cnt == '0) && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            cmp_q    <= '0;
            cnt      <= '0;
            en       <= 1'b0;
            os       <= 1'b0;
        end else begin
            if (period_wr) period_q <= wdata;
            if (cmp_wr)    cmp_q    <= wdata;
            if (ctrl_wr)   os       <= os_in;
            if (stop) begin
                en <= 1'b0;
            end else if (start) begin
                en  <= 1'b1;
                cnt <= period_q;
            end else if (en && tick) begin
                if (cnt == '0) begin
                    if (os) en  <= 1'b0;
                    else    cnt <= period_q;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (expire) flag <= 1'b1;
        else if (clr_wr) flag <= 1'b0;
    end

    assign raw    = en && (cnt > cmp_q);
    assign active = en;

    // R2: the counter only moves on a tick or a control write
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ctrl_wr) |=> $stable(cnt));
    // R6: a flag can only rise after a tick
    p_flag_src_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick));
    // R5: a one-shot self-stop happens only at zero
    p_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(en) && $past(os) && !$past(ctrl_wr)) |-> ($past(cnt) == '0));

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
    import pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            dz_en,
    input  logic [DT_W-1:0] dt,
    input  logic            raw_a,
    input  logic            act_a,
    input  logic            raw_b,
    output logic            q_a,
    output logic            q_b
);
    logic [1:0]      src;
    logic [1:0]      q;
    logic [DT_W-1:0] dcnt [2];

    assign src[0] = raw_a;
    assign src[1] = dz_en ? (act_a && !raw_a) : raw_b;

    for (genvar k = 0; k < 2; k++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) begin
                q[k]    <= 1'b0;
                dcnt[k] <= '0;
            end else if (!dz_en) begin
                q[k]    <= src[k];
                dcnt[k] <= '0;
            end else if (!src[k]) begin
                q[k]    <= 1'b0;
                dcnt[k] <= '0;
            end else if (dcnt[k] == dt) begin
                q[k]    <= 1'b1;
            end else begin
                dcnt[k] <= dcnt[k] + 1'b1;
            end
        end
    end

    assign q_a = q[0];
    assign q_b = q[1];

    // R8: complementary outputs never overlap once dead time is settled
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        (dz_en && $past(dz_en)) |-> !(q_a && q_b));
    // R7: a delayed rise requires the source to have been high
    p_rise_src_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(q_a) && dz_en && $past(dz_en)) |-> $past(raw_a));

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_pkg::*;
#(
    parameter int N_PAIRS = 2,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [2*N_PAIRS-1:0]   pwm_out,
    output logic [2*N_PAIRS-1:0]   ch_active,
    output logic [2*N_PAIRS-1:0]   irq_flag
);
    localparam int N_CH     = 2 * N_PAIRS;
    localparam int CH_BASE  = 3 * N_PAIRS;
    localparam int CTRL_ADR = CH_BASE + 2 * N_CH;
    localparam int CLR_ADR  = CTRL_ADR + 1;
    localparam int DZ_BIT   = DT_W;

    pair_cfg_t        cfg  [N_PAIRS];
    logic [N_PAIRS-1:0] tick;
    logic [N_CH-1:0]  raw;
    logic             ctrl_wr;
    logic             clr_wr;

    assign ctrl_wr = wr_en && (int'(wr_addr) == CTRL_ADR);
    assign clr_wr  = wr_en && (int'(wr_addr) == CLR_ADR);

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[p] <= '{pre: '0, div: DIV_1, dz_en: 1'b0, dt: '0};
            end else if (wr_en) begin
                if (int'(wr_addr) == 3 * p)
                    cfg[p].pre <= wr_data[PRE_W-1:0];
                if (int'(wr_addr) == 3 * p + 1)
                    cfg[p].div <= div_sel_e'(wr_data[2:0]);
                if (int'(wr_addr) == 3 * p + 2) begin
                    cfg[p].dt    <= wr_data[DT_W-1:0];
                    cfg[p].dz_en <= wr_data[DZ_BIT];
                end
            end
        end

        pwm_tick_gen u_tick (
            .clk  (clk),
            .rst  (rst),
            .pre  (cfg[p].pre),
            .div  (cfg[p].div),
            .tick (tick[p])
        );

        pwm_deadband u_dz (
            .clk   (clk),
            .rst   (rst),
            .dz_en (cfg[p].dz_en),
            .dt    (cfg[p].dt),
            .raw_a (raw[2*p]),
            .act_a (ch_active[2*p]),
            .raw_b (raw[2*p+1]),
            .q_a   (pwm_out[2*p]),
            .q_b   (pwm_out[2*p+1])
        );
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick[c/2]),
            .period_wr (wr_en && (int'(wr_addr) == CH_BASE + 2 * c)),
            .cmp_wr    (wr_en && (int'(wr_addr) == CH_BASE + 2 * c + 1)),
            .wdata     (wr_data[CNT_W-1:0]),
            .ctrl_wr   (ctrl_wr),
            .en_in     (wr_data[c]),
            .os_in     (wr_data[N_CH + c]),
            .clr_wr    (clr_wr && wr_data[c]),
            .raw       (raw[c]),
            .active    (ch_active[c]),
            .flag      (irq_flag[c])
        );
    end

    // R10: a channel that was idle and not started keeps its output low
    p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(ch_active == '0) && !$past(ctrl_wr) && $past(rst) == 1'b0
         && $past(pwm_out == '0)) |-> (pwm_out == '0));

endmodule

// File: tb/pwm_quad_test.sv
module pwm_quad_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm_out, ch_active, irq_flag;

    int total = 0;
    int bad   = 0;
    int hc [4];
    int ov;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_quad uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .ch_active(ch_active),
        .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a[3:0];
        wr_data = d[15:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic sample(input int n);
        for (int c = 0; c < 4; c++) hc[c] = 0;
        ov = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) if (pwm_out[c]) hc[c]++;
            if (pwm_out[0] && pwm_out[1]) ov++;
        end
    endtask

    task automatic t_reset;
        chk("R1 outputs", int'(pwm_out), 0);
        chk("R1 active", int'(ch_active), 0);
        chk("R1 flags", int'(irq_flag), 0);
    endtask

    task automatic t_autoreload;
        wr(0, 0); wr(1, 0);
        wr(6, 4); wr(7, 1);
        wr(8, 9); wr(9, 4);
        wr(14, 3);
        repeat (20) @(negedge clk);
        sample(50);
        chk("R3 ch0 high count", hc[0], 30);
        chk("R9 ch1 independent high count", hc[1], 25);
        chk("R10 active after start", int'(ch_active[1:0]), 3);
    endtask

    task automatic t_compare;
        wr(9, 9);
        repeat (12) @(negedge clk);
        sample(50);
        chk("R4 compare equals period", hc[1], 0);
        wr(9, 0);
        repeat (12) @(negedge clk);
        sample(50);
        chk("R3 compare zero", hc[1], 45);
    endtask

    task automatic t_irq;
        chk("R6 flag ch0 set", int'(irq_flag[0]), 1);
        chk("R6 flag ch1 set", int'(irq_flag[1]), 1);
        wr(14, 0);
        repeat (2) @(negedge clk);
        chk("R10 active after stop", int'(ch_active), 0);
        sample(10);
        chk("R10 ch0 low after stop", hc[0], 0);
        wr(15, 2);
        chk("R6 clear ch1", int'(irq_flag[1]), 0);
        chk("R6 zero bit leaves ch0", int'(irq_flag[0]), 1);
        wr(15, 1);
        chk("R6 clear ch0", int'(irq_flag[0]), 0);
    endtask

    task automatic t_oneshot;
        wr(8, 3);
        wr(14, (1 << 1) | (1 << 5));
        sample(30);
        chk("R5 one-shot high count", hc[1], 3);
        chk("R5 active cleared", int'(ch_active[1]), 0);
        chk("R5 flag set", int'(irq_flag[1]), 1);
        chk("R5 output low", int'(pwm_out[1]), 0);
    endtask

    task automatic t_deadzone;
        wr(2, 'h101);
        wr(14, 1);
        repeat (20) @(negedge clk);
        sample(50);
        chk("R7 dt1 first output", hc[0], 20);
        chk("R7 dt1 complement output", hc[1], 10);
        chk("R8 dt1 overlap", ov, 0);
        wr(2, 'h100);
        repeat (10) @(negedge clk);
        sample(50);
        chk("R7 dt0 first output", hc[0], 30);
        chk("R7 dt0 complement output", hc[1], 20);
        chk("R8 dt0 overlap", ov, 0);
    endtask

    task automatic t_prescale;
        wr(3, 1); wr(4, 1);
        wr(10, 4); wr(11, 1);
        wr(14, 4);
        repeat (40) @(negedge clk);
        sample(80);
        chk("R2 prescale1 div2 high count", hc[2], 48);
        chk("R9 idle ch3 stays low", hc[3], 0);
        wr(4, 7);
        repeat (200) @(negedge clk);
        sample(160);
        chk("R2 clamped divider code", hc[2], 96);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_autoreload();
        t_compare();
        t_irq();
        t_oneshot();
        t_deadzone();
        t_prescale();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule